// File: doc/BRIEF.md
# PWM Time-Base Counter With Phase Synchronization

This block is the timing reference of one PWM channel. A 16-bit counter runs in an up, a down or an up-down (symmetric) pattern against a period value. Compare and output-shaping logic elsewhere in the channel use the counter value and its direction. The period is held in two registers. Writes land in a shadow copy, and the copy that drives the counter takes the shadow value on the cycle the counter sits at zero. A write marked immediate bypasses the shadow.

Several channels can be chained. Each instance emits a sync pulse, taken either from its own incoming sync, from its counter at zero, or from its counter matching a compare-B value. When phase loading is enabled, an incoming sync pulse or a software strobe forces the counter to a programmed phase offset. In up-down mode a direction bit chooses which way the counter moves after that load. A shared enable input freezes every instance, so a whole chain can be released in the same cycle. A sticky status bit records that the counter reached its all-ones value.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0, the direction output is 1 (up), the max-reached flag is 0, and both period copies hold the reset period (parameter, default 0).
- R2: Mode 0 (up): each enabled cycle the counter increments, and from a value at or above the active period it goes to 0. The period is active period + 1 cycles. dir_o is 1.
- R3: Mode 1 (down): each enabled cycle the counter decrements, and from 0 it loads the period that is active after that edge. dir_o is 0.
- R4: Mode 2 (up-down): the counter rises to the active period and then falls to 0, giving a period of 2 × active period. dir_o shows the direction of the step that produced the current value. With an active period of 0 the counter stays at 0. Mode 3 holds the counter.
- R5: A period write with immediate clear only changes the shadow copy. The active copy takes the shadow value at the edge where the counter is 0 and enabled, and at no other time.
- R6: A period write with immediate set loads both copies at the next edge, and that edge's counter step still uses the old active period.
- R7: When phase enable is 1 and sync_i is high in an enabled cycle, the counter takes phase_i at the next edge. With phase enable 0 the pulse has no effect on the count.
- R8: sw_sync_i has the same effect as sync_i. The two are ORed.
- R9: After a phase load in up-down mode, dir_o equals phase_dir_i (1 = up) and counting continues in that direction.
- R10: sync_o follows the select input: 0 passes the ORed sync inputs, 1 gives counter-equals-zero, 2 gives counter-equals-cmpb_i, and 3 gives a constant 0.
- R11: While clk_en_i is 0 the counter and direction hold, sync loads are ignored, and zero_o, prd_o and the compare-B match are 0.
- R12: max_o becomes 1 at the edge after the counter equals 0xFFFF and stays 1 until a max_clr_i pulse. If both happen in the same cycle, the set wins.
- R13: zero_o is high when the counter is 0 and prd_o is high when it equals the active period. Each is a one-cycle pulse in normal counting with a nonzero period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Global count enable |
| mode_i | input | 2 | 0 up, 1 down, 2 up-down, 3 hold |
| prd_wr_i | input | 1 | Period write strobe |
| prd_imm_i | input | 1 | Write goes straight to the active copy |
| prd_wdata_i | input | 16 | Period write value |
| phase_i | input | 16 | Phase offset loaded on sync |
| phase_en_i | input | 1 | Enable phase load on sync |
| phase_dir_i | input | 1 | Up-down direction after phase load (1 up) |
| sync_sel_i | input | 2 | Sync-out source select |
| cmpb_i | input | 16 | Compare-B value for sync-out |
| sync_i | input | 1 | Sync pulse from the previous instance |
| sw_sync_i | input | 1 | Software sync strobe |
| max_clr_i | input | 1 | Clear max-reached flag |
| cnt_o | output | 16 | Counter value |
| dir_o | output | 1 | Count direction (1 up) |
| zero_o | output | 1 | Counter equals zero |
| prd_o | output | 1 | Counter equals active period |
| sync_o | output | 1 | Sync output to the next instance |
| max_o | output | 1 | Max-reached status |

## Verification
Two pairs of events can land in the same cycle, and each pair is provoked on purpose. First, a period write is issued while the counter is mid-period, in both shadow and immediate form. The bench then checks that the wrap point moves only at the next zero (shadow) or at once (immediate), while the step on the write edge still uses the old period. Second, a clear strobe for the max flag is applied in the same cycle the counter sits at 0xFFFF, and the flag must survive. A phase load is also placed on top of normal counting, where it must override the step, and under a low enable, where it must be ignored.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
  typedef enum logic [1:0] {
    CNT_UP     = 2'd0,
    CNT_DOWN   = 2'd1,
    CNT_UPDOWN = 2'd2,
    CNT_HOLD   = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SO_PASS = 2'd0,
    SO_ZERO = 2'd1,
    SO_CMPB = 2'd2,
    SO_OFF  = 2'd3
  } so_sel_e;
endpackage

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
  parameter int unsigned W       = 16,
  parameter int unsigned RST_PRD = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         imm_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  output logic [W-1:0] act_o,
  output logic [W-1:0] next_o
);
  localparam logic [W-1:0] RST_V = W'(RST_PRD);

  logic [W-1:0] shd_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= RST_V;
      act_q <= RST_V;
    end else begin
      if (wr_i) shd_q <= wdata_i;
      if (wr_i && imm_i) act_q <= wdata_i;
      else if (load_i)   act_q <= shd_q;
    end
  end

  // value the active copy holds after this edge
  always_comb begin
    if (wr_i && imm_i) next_o = wdata_i;
    else if (load_i)   next_o = shd_q;
    else               next_o = act_q;
  end

  assign act_o = act_q;

  // R5
  act_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(wr_i && imm_i)) |=> $stable(act_q));

  // R6
  imm_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && imm_i) |=> (act_q == $past(wdata_i)));
endmodule

// File: rtl/pwm_tb_core.sv
module pwm_tb_core
  import pwm_tb_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  cnt_mode_e    mode_i,
  input  logic [W-1:0] prd_i,
  input  logic [W-1:0] prd_next_i,
  input  logic [W-1:0] phase_i,
  input  logic         phase_en_i,
  input  logic         phase_dir_i,
  input  logic         sync_evt_i,
  output logic [W-1:0] cnt_o,
  output logic         up_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         up_q;
  logic         ph_ld;

  assign ph_ld = phase_en_i && sync_evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (en_i) begin
      if (ph_ld) begin
        cnt_q <= phase_i;
        case (mode_i)
          CNT_UP:     up_q <= 1'b1;
          CNT_DOWN:   up_q <= 1'b0;
          CNT_UPDOWN: up_q <= phase_dir_i;
          default:    up_q <= up_q;
        endcase
      end else begin
        case (mode_i)
          CNT_UP: begin
            up_q  <= 1'b1;
            cnt_q <= (cnt_q >= prd_i) ? '0 : cnt_q + ONE;
          end
          CNT_DOWN: begin
            up_q  <= 1'b0;
            cnt_q <= (cnt_q == '0) ? prd_next_i : cnt_q - ONE;
          end
          CNT_UPDOWN: begin
            if (prd_i == '0) begin
              cnt_q <= '0;
            end else if (up_q) begin
              if (cnt_q >= prd_i) begin
                up_q  <= 1'b0;
                cnt_q <= cnt_q - ONE;
              end else begin
                cnt_q <= cnt_q + ONE;
              end
            end else if (cnt_q == '0) begin
              up_q  <= 1'b1;
              cnt_q <= cnt_q + ONE;
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
          default: cnt_q <= cnt_q;
        endcase
      end
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;

  // R11
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(up_q)));

  // R7
  phase_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ph_ld) |=> (cnt_q == $past(phase_i)));

  // R2
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ph_ld && mode_i == CNT_UP && cnt_q < prd_i) |=> (cnt_q == $past(cnt_q) + ONE));

  // R3
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ph_ld && mode_i == CNT_DOWN && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/pwm_tb_syncout.sv
module pwm_tb_syncout
  import pwm_tb_pkg::*;
(
  input  so_sel_e sel_i,
  input  logic    sync_evt_i,
  input  logic    zero_i,
  input  logic    cmpb_hit_i,
  output logic    sync_o
);
  always_comb begin
    case (sel_i)
      SO_PASS: sync_o = sync_evt_i;
      SO_ZERO: sync_o = zero_i;
      SO_CMPB: sync_o = cmpb_hit_i;
      default: sync_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int unsigned W       = 16,
  parameter int unsigned RST_PRD = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clk_en_i,
  input  logic [1:0]   mode_i,
  input  logic         prd_wr_i,
  input  logic         prd_imm_i,
  input  logic [W-1:0] prd_wdata_i,
  input  logic [W-1:0] phase_i,
  input  logic         phase_en_i,
  input  logic         phase_dir_i,
  input  logic [1:0]   sync_sel_i,
  input  logic [W-1:0] cmpb_i,
  input  logic         sync_i,
  input  logic         sw_sync_i,
  input  logic         max_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_o,
  output logic         zero_o,
  output logic         prd_o,
  output logic         sync_o,
  output logic         max_o
);
  localparam logic [W-1:0] MAX_V = '1;

  cnt_mode_e    mode;
  logic [W-1:0] cnt, prd_act, prd_next;
  logic         sync_evt, zero_hit, cmpb_hit, max_q;

  assign mode     = cnt_mode_e'(mode_i);
  assign sync_evt = sync_i | sw_sync_i;
  assign zero_hit = clk_en_i && (cnt == '0);
  assign cmpb_hit = clk_en_i && (cnt == cmpb_i);

  pwm_tb_period #(.W(W), .RST_PRD(RST_PRD)) u_prd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (prd_wr_i),
    .imm_i   (prd_imm_i),
    .wdata_i (prd_wdata_i),
    .load_i  (zero_hit),
    .act_o   (prd_act),
    .next_o  (prd_next)
  );

  pwm_tb_core #(.W(W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (clk_en_i),
    .mode_i      (mode),
    .prd_i       (prd_act),
    .prd_next_i  (prd_next),
    .phase_i     (phase_i),
    .phase_en_i  (phase_en_i),
    .phase_dir_i (phase_dir_i),
    .sync_evt_i  (sync_evt),
    .cnt_o       (cnt),
    .up_o        (dir_o)
  );

  pwm_tb_syncout u_so (
    .sel_i      (so_sel_e'(sync_sel_i)),
    .sync_evt_i (sync_evt),
    .zero_i     (zero_hit),
    .cmpb_hit_i (cmpb_hit),
    .sync_o     (sync_o)
  );

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             max_q <= 1'b0;
    else if (cnt == MAX_V)   max_q <= 1'b1;
    else if (max_clr_i)      max_q <= 1'b0;
  end

  assign cnt_o  = cnt;
  assign zero_o = zero_hit;
  assign prd_o  = clk_en_i && (cnt == prd_act);
  assign max_o  = max_q;

  // R12
  max_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == MAX_V) |=> max_q);

  // R12
  max_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_q && !max_clr_i) |=> max_q);

  // R13
  zero_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && mode != CNT_HOLD && prd_act != '0 && prd_next != '0 &&
     !(phase_en_i && sync_evt)) |=> !zero_o);
endmodule

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en, prd_wr, prd_imm, phase_en, phase_dir, sync, sw_sync, max_clr;
  logic [1:0]  mode, sync_sel;
  logic [15:0] prd_wdata, phase, cmpb;
  logic [15:0] cnt_o;
  logic        dir_o, zero_o, prd_o, sync_o, max_o;

  int n_chk = 0, n_fail = 0;
  int e, d, act, shd;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_timebase dut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_i(clk_en), .mode_i(mode),
    .prd_wr_i(prd_wr), .prd_imm_i(prd_imm), .prd_wdata_i(prd_wdata),
    .phase_i(phase), .phase_en_i(phase_en), .phase_dir_i(phase_dir),
    .sync_sel_i(sync_sel), .cmpb_i(cmpb), .sync_i(sync), .sw_sync_i(sw_sync),
    .max_clr_i(max_clr), .cnt_o(cnt_o), .dir_o(dir_o), .zero_o(zero_o),
    .prd_o(prd_o), .sync_o(sync_o), .max_o(max_o)
  );

  task automatic chk(string r, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", r, got, exp);
    end
  endtask

  // bench model of one enabled step
  function automatic void mstep(int m);
    int ne;
    ne = e;
    if (m == 0) begin
      ne = (e >= act) ? 0 : e + 1;
      if (e == 0) act = shd;
      d = 1;
    end else if (m == 1) begin
      if (e == 0) begin act = shd; ne = act; end
      else ne = e - 1;
      d = 0;
    end else if (m == 2) begin
      if (act == 0) ne = 0;
      else if (d == 1 && e >= act) begin d = 0; ne = e - 1; end
      else if (d == 1) ne = e + 1;
      else if (e == 0) begin d = 1; ne = 1; end
      else ne = e - 1;
      if (e == 0) act = shd;
    end
    e = ne;
  endfunction

  task automatic run(int m, int n, string r);
    repeat (n) begin
      @(negedge clk);
      mstep(m);
      chk(r, cnt_o, e);
      chk(r, dir_o, d);
      chk("R13 zero", zero_o, (e == 0));
      chk("R13 prd", prd_o, (e == act));
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; clk_en = 0; prd_wr = 0; prd_imm = 0; phase_en = 0; phase_dir = 0;
    sync = 0; sw_sync = 0; max_clr = 0; mode = 0; sync_sel = 0;
    prd_wdata = 0; phase = 0; cmpb = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    e = 0; d = 1; act = 0; shd = 0;
  endtask

  task automatic wr_imm(int v);
    prd_wr = 1; prd_imm = 1; prd_wdata = 16'(v);
    @(negedge clk);
    prd_wr = 0; prd_imm = 0;
    act = v; shd = v;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cnt", cnt_o, 0);
    chk("R1 dir", dir_o, 1);
    chk("R1 max", max_o, 0);
    chk("R1 zero", zero_o, 0);
    chk("R1 sync_o", sync_o, 0);
  endtask

  task automatic t_up();
    do_reset(); wr_imm(4); mode = 0; clk_en = 1;
    run(0, 12, "R2");
  endtask

  task automatic t_down();
    do_reset(); wr_imm(3); mode = 1; clk_en = 1;
    run(1, 10, "R3");
  endtask

  task automatic t_updown();
    do_reset(); wr_imm(3); mode = 2; clk_en = 1;
    run(2, 14, "R4");
  endtask

  task automatic t_shadow();
    do_reset(); wr_imm(5); mode = 0; clk_en = 1;
    run(0, 2, "R5");
    prd_wr = 1; prd_imm = 0; prd_wdata = 16'd2; shd = 2;
    run(0, 1, "R5");
    prd_wr = 0;
    run(0, 8, "R5");
  endtask

  task automatic t_imm();
    do_reset(); wr_imm(5); mode = 0; clk_en = 1;
    run(0, 2, "R6");
    prd_wr = 1; prd_imm = 1; prd_wdata = 16'd2;
    @(negedge clk);
    prd_wr = 0; prd_imm = 0;
    e = 3; act = 2; shd = 2;
    chk("R6 old period on write edge", cnt_o, 3);
    run(0, 5, "R6");
  endtask

  task automatic t_phase();
    do_reset(); wr_imm(9); mode = 0; phase = 16'd6; phase_en = 1; clk_en = 1;
    run(0, 2, "R7");
    sync = 1; @(negedge clk); sync = 0; e = 6;
    chk("R7 load", cnt_o, 6);
    run(0, 1, "R7");
    phase_en = 0; sync = 1; @(negedge clk); sync = 0; mstep(0);
    chk("R7 ignored", cnt_o, 8);
    phase_en = 1; phase = 16'd2; sw_sync = 1; @(negedge clk); sw_sync = 0; e = 2;
    chk("R8 sw load", cnt_o, 2);
    run(0, 2, "R8");
  endtask

  task automatic t_phdir();
    do_reset(); wr_imm(9); mode = 2; clk_en = 1;
    run(2, 3, "R4");
    phase = 16'd5; phase_en = 1; phase_dir = 0;
    sync = 1; @(negedge clk); sync = 0; e = 5; d = 0;
    chk("R9 cnt", cnt_o, 5); chk("R9 dir", dir_o, 0);
    run(2, 2, "R9");
    phase_dir = 1;
    sync = 1; @(negedge clk); sync = 0; e = 5; d = 1;
    chk("R9 cnt", cnt_o, 5); chk("R9 dir", dir_o, 1);
    run(2, 6, "R9");
  endtask

  task automatic t_syncout();
    do_reset(); wr_imm(4); mode = 0; cmpb = 16'd3; sync_sel = 1; clk_en = 1;
    repeat (6) begin @(negedge clk); mstep(0); chk("R10 zero src", sync_o, (e == 0)); end
    sync_sel = 2;
    repeat (6) begin @(negedge clk); mstep(0); chk("R10 cmpb src", sync_o, (e == 3)); end
    sync_sel = 0; sync = 1; #1;
    chk("R10 pass hw", sync_o, 1);
    sync = 0; sw_sync = 1; #1;
    chk("R10 pass sw", sync_o, 1);
    sw_sync = 0; #1;
    chk("R10 pass idle", sync_o, 0);
    sync_sel = 3; sync = 1; #1;
    chk("R10 off", sync_o, 0);
    sync = 0;
    @(negedge clk);
  endtask

  task automatic t_freeze();
    do_reset(); wr_imm(4); mode = 0; clk_en = 1;
    run(0, 3, "R11");
    clk_en = 0; phase_en = 1; phase = 16'd1; sync = 1;
    repeat (3) begin
      @(negedge clk);
      chk("R11 hold", cnt_o, 3);
      chk("R11 prd gated", prd_o, 0);
    end
    sync = 0; phase_en = 0; clk_en = 1;
    run(0, 2, "R11");
    clk_en = 0; #1;
    chk("R11 zero gated", zero_o, 0);
    @(negedge clk);
    chk("R11 hold at zero", cnt_o, 0);
  endtask

  task automatic t_max();
    do_reset(); wr_imm(65535); mode = 0; phase = 16'hFFFE; phase_en = 1; clk_en = 1;
    sync = 1; @(negedge clk); sync = 0;
    chk("R12 cnt", cnt_o, 65534); chk("R12 not yet", max_o, 0);
    @(negedge clk);
    chk("R12 cnt max", cnt_o, 65535); chk("R12 not yet", max_o, 0);
    @(negedge clk);
    chk("R12 wrap", cnt_o, 0); chk("R12 set", max_o, 1);
    @(negedge clk);
    chk("R12 sticky", max_o, 1);
    max_clr = 1; @(negedge clk); max_clr = 0;
    chk("R12 clear", max_o, 0);
    phase = 16'hFFFF; sync = 1; @(negedge clk); sync = 0;
    chk("R12 cnt max", cnt_o, 65535);
    max_clr = 1; @(negedge clk); max_clr = 0;
    chk("R12 set wins", max_o, 1);
  endtask

  initial begin
    t_reset();
    t_up();
    t_down();
    t_updown();
    t_shadow();
    t_imm();
    t_phase();
    t_phdir();
    t_syncout();
    t_freeze();
    t_max();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule